// File: doc/BRIEF.md
# Lock-Aware DMA Request Gate

This block sits between a DMA engine and the bus interface of a processor. The engine raises a plain active-high request. The block decides when the active-low request toward the processor may fall. It never starts a request in a cycle where the processor's bus-lock output is high. After lock has been low, it also waits a programmable number of clean cycles before it starts one. This way the processor's own late sampling of lock can never meet a fresh request on the same edge.

Once the processor grants the bus, the block watches the session for a DMA address strobe. If the engine gives up the bus without issuing any strobe, the block drives a one-cycle forced-strobe pulse before it releases the request. The processor therefore always sees at least one strobe per session and is never left waiting in hold until a timeout.

Top module: `dma_lock_gate`

## Requirements
- R1: While `rst_n` is low, and afterwards until a request is launched, `req_n` and `force_as_n` are both high (inactive).
- R2: `req_n` never falls after an edge at which `bus_lock` was sampled high. This includes the case where lock and the engine request first appear at the same edge.
- R3: `req_n` falls after the first edge at which all of these hold: `eng_req` is 1, `gnt_n` is 1, `bus_lock` is 0, and `bus_lock` was 0 at each of the previous `LOCK_GUARD` edges (default 1). The count of clean edges starts at zero on reset.
- R4: Once low, `req_n` stays low until `gnt_n` is sampled low. This holds even if the engine drops its request or lock rises in the meantime.
- R5: During a granted session, a strobe means `eng_as_n` = 0. If `eng_req` is sampled 0 and at least one strobe was sampled during the session, including at that same edge, then `req_n` goes high after that edge and `force_as_n` stays high.
- R6: If `eng_req` is sampled 0 in a session that had no strobe, `force_as_n` is low for exactly one cycle after that edge, with `req_n` still low. `req_n` goes high at the following edge.
- R7: A strobe sampled before the grant is seen does not count for the session.
- R8: No new request is launched while `gnt_n` is still low from the previous session. Launching resumes once `gnt_n` is high.
- R9: Changes of `bus_lock` during a granted session do not affect `req_n` or `force_as_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| eng_req | input | 1 | Raw request from the DMA engine, active high |
| bus_lock | input | 1 | Processor bus-lock output, active high |
| gnt_n | input | 1 | Grant from the processor, active low |
| eng_as_n | input | 1 | DMA address strobe from the engine, active low |
| req_n | output | 1 | Gated request to the processor, active low, registered |
| force_as_n | output | 1 | Forced-strobe pulse, active low, registered |

## Verification
The bench raises lock on the same edge as the engine request. A gate that looked only at the current lock level, with no clean-cycle history, would launch one cycle too early. The bench tests empty sessions, strobes issued before the grant, and a strobe that lands on the very edge where the engine drops its request. A design that carried stale strobe state, or ignored the final-edge strobe, would either skip the forced pulse or emit a spurious one. The bench also drops the engine request before the grant, moves lock during a session, and re-requests while the old grant is still low. Any of these would expose a design that releases the request early or launches into a bus that has not been handed back.

// File: rtl/dlg_pkg.sv
// Package dlg_pkg
// Shared types for the lock-aware DMA request gate.
package dlg_pkg;

    // Session sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // no request outstanding
        ST_ASK   = 2'd1,  // request driven, waiting for grant
        ST_SESS  = 2'd2,  // bus granted, engine active
        ST_FORCE = 2'd3   // forced strobe pulse being driven
    } dlg_state_e;

endpackage

// File: rtl/dlg_lock_guard.sv
// Module dlg_lock_guard
// Counts consecutive edges at which bus lock was sampled low, saturating
// at GUARD. A launch is allowed only when lock is low now and the counter
// has reached GUARD.
// Assumes: bus_lock is synchronous to clk. The counter is zero after reset.
module dlg_lock_guard #(
    parameter int GUARD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_lock,
    output logic launch_ok
);
    localparam int CW = $clog2(GUARD + 1) < 1 ? 1 : $clog2(GUARD + 1);
    localparam logic [CW-1:0] GUARD_V = CW'(GUARD);

    logic [CW-1:0] clean_cnt;

    // Track how many clean (unlocked) edges have passed since lock was last high
    always_ff @(posedge clk) begin
        if (!rst_n)
            clean_cnt <= '0;
        else if (bus_lock)
            clean_cnt <= '0;
        else if (clean_cnt != GUARD_V)
            clean_cnt <= clean_cnt + 1'b1;
    end

    // Launch permission: lock low now and enough clean history
    always_comb launch_ok = !bus_lock && (clean_cnt == GUARD_V);

endmodule

// File: rtl/dlg_strobe_watch.sv
// Module dlg_strobe_watch
// Remembers whether an address strobe has been seen in the current granted
// session. The output includes a strobe present in the current cycle.
// Assumes: clear_i and track_i are never high together.
module dlg_strobe_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic track_i,
    input  logic as_n,
    output logic seen_o
);
    logic seen_q;
    logic hit;

    // A strobe only counts while the session is being tracked
    always_comb hit = track_i && !as_n;

    // Sticky flag, cleared while a grant is awaited
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            seen_q <= 1'b0;
        else if (hit)
            seen_q <= 1'b1;
    end

    // Strobe seen so far, including this cycle
    always_comb seen_o = seen_q || hit;

endmodule

// File: rtl/dlg_session_fsm.sv
// Module dlg_session_fsm
// Sequences one DMA session: launch, wait for grant, run, optional forced
// strobe, release. Both outputs are registered and reset high.
// Assumes: launch_ok comes from the lock guard; seen comes from the strobe watch.
module dlg_session_fsm
    import dlg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eng_req,
    input  logic       gnt_n,
    input  logic       launch_ok,
    input  logic       seen,
    output dlg_state_e state,
    output logic       req_n,
    output logic       force_as_n
);
    dlg_state_e state_q;

    // State and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            req_n      <= 1'b1;
            force_as_n <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (eng_req && gnt_n && launch_ok) begin
                        state_q <= ST_ASK;
                        req_n   <= 1'b0;
                    end
                end
                ST_ASK: begin
                    if (!gnt_n)
                        state_q <= ST_SESS;
                end
                ST_SESS: begin
                    if (!eng_req) begin
                        if (seen) begin
                            state_q <= ST_IDLE;
                            req_n   <= 1'b1;
                        end else begin
                            state_q    <= ST_FORCE;
                            force_as_n <= 1'b0;
                        end
                    end
                end
                ST_FORCE: begin
                    state_q    <= ST_IDLE;
                    req_n      <= 1'b1;
                    force_as_n <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Expose the state to the strobe watch
    always_comb state = state_q;

endmodule

// File: rtl/dma_lock_gate.sv
// Module dma_lock_gate (top)
// Gates a DMA engine request toward the processor around bus-lock
// sequences, and makes sure each granted session carries a strobe.
// Assumes: all inputs are synchronous to clk; synchronous active-low reset.
module dma_lock_gate
    import dlg_pkg::*;
#(
    parameter int LOCK_GUARD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eng_req,
    input  logic bus_lock,
    input  logic gnt_n,
    input  logic eng_as_n,
    output logic req_n,
    output logic force_as_n
);
    logic       launch_ok;
    logic       seen;
    dlg_state_e state;
    logic       in_ask;
    logic       in_sess;

    // Decode the phases the strobe watch cares about
    always_comb begin
        in_ask  = (state == ST_ASK);
        in_sess = (state == ST_SESS);
    end

    dlg_lock_guard #(.GUARD(LOCK_GUARD)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_lock  (bus_lock),
        .launch_ok (launch_ok)
    );

    dlg_strobe_watch u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (in_ask),
        .track_i (in_sess),
        .as_n    (eng_as_n),
        .seen_o  (seen)
    );

    dlg_session_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .eng_req    (eng_req),
        .gnt_n      (gnt_n),
        .launch_ok  (launch_ok),
        .seen       (seen),
        .state      (state),
        .req_n      (req_n),
        .force_as_n (force_as_n)
    );

endmodule

// File: rtl/dlg_checker.sv
// Module dlg_checker
// Port-level properties of the lock-aware DMA request gate, bound to the top.
module dlg_checker (
    input logic clk,
    input logic rst_n,
    input logic eng_req,
    input logic bus_lock,
    input logic gnt_n,
    input logic eng_as_n,
    input logic req_n,
    input logic force_as_n
);
    // R1: outputs inactive right after a reset cycle
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (req_n && force_as_n));

    // R2: no launch after an edge with lock high
    a_r2_no_launch_under_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> !$past(bus_lock));

    // R4: request held until grant is seen
    a_r4_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && gnt_n) |=> !req_n);

    // R5: release only after the engine dropped its request
    a_r5_release_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_n) |-> (!$past(eng_req) || !$past(force_as_n)));

    // R6: forced strobe lasts one cycle and is followed by release
    a_r6_force_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !force_as_n |=> (force_as_n && req_n));

    // R8: no launch while the previous grant is still low
    a_r8_no_launch_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> $past(gnt_n));

    // R6: forced strobe only while the request is still driven
    a_r6_force_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        !force_as_n |-> !req_n);

endmodule

bind dma_lock_gate dlg_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eng_req    (eng_req),
    .bus_lock   (bus_lock),
    .gnt_n      (gnt_n),
    .eng_as_n   (eng_as_n),
    .req_n      (req_n),
    .force_as_n (force_as_n)
);

// File: tb/dma_lock_gate_tb.sv
// Directed bench for dma_lock_gate: one task per scenario.
module dma_lock_gate_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eng_req = 1'b0;
    logic bus_lock = 1'b0;
    logic gnt_n = 1'b1;
    logic eng_as_n = 1'b1;
    logic req_n;
    logic force_as_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dma_lock_gate #(.LOCK_GUARD(1)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .eng_req    (eng_req),
        .bus_lock   (bus_lock),
        .gnt_n      (gnt_n),
        .eng_as_n   (eng_as_n),
        .req_n      (req_n),
        .force_as_n (force_as_n)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; eng_req = 1'b1;
        step(3);
        chk("R1 req_n in reset", req_n, 1'b1);
        chk("R1 force_as_n in reset", force_as_n, 1'b1);
        eng_req = 1'b0; rst_n = 1'b1;
        step(2);
        chk("R1 req_n after reset", req_n, 1'b1);
    endtask

    task automatic t_plain_launch();
        eng_req = 1'b1;
        step(1);
        chk("R3 launch with clean lock", req_n, 1'b0);
        gnt_n = 1'b0;
        step(1);
        eng_as_n = 1'b0;
        step(1);
        eng_as_n = 1'b1; eng_req = 1'b0;
        step(1);
        chk("R5 release after strobe", req_n, 1'b1);
        chk("R5 no forced strobe", force_as_n, 1'b1);
        gnt_n = 1'b1;
        step(2);
    endtask

    task automatic t_lock_same_edge();
        bus_lock = 1'b1; eng_req = 1'b1;
        step(1);
        chk("R2 no launch with lock", req_n, 1'b1);
        bus_lock = 1'b0;
        step(1);
        chk("R3 guard cycle after lock", req_n, 1'b1);
        step(1);
        chk("R3 launch after guard", req_n, 1'b0);
        gnt_n = 1'b0;
        step(1);
        eng_as_n = 1'b0; eng_req = 1'b0;
        step(1);
        chk("R5 strobe on drop edge releases", req_n, 1'b1);
        chk("R5 strobe on drop edge no force", force_as_n, 1'b1);
        gnt_n = 1'b1; eng_as_n = 1'b1;
        step(2);
    endtask

    task automatic t_lock_in_session();
        eng_req = 1'b1;
        step(1);
        chk("R3 launch", req_n, 1'b0);
        bus_lock = 1'b1;
        step(3);
        chk("R4 held under lock before grant", req_n, 1'b0);
        gnt_n = 1'b0;
        step(1);
        bus_lock = 1'b0;
        step(1);
        bus_lock = 1'b1;
        step(1);
        chk("R9 req_n unaffected by lock", req_n, 1'b0);
        chk("R9 force unaffected by lock", force_as_n, 1'b1);
        eng_as_n = 1'b0;
        step(1);
        eng_as_n = 1'b1; eng_req = 1'b0; bus_lock = 1'b0;
        step(1);
        chk("R5 release after session", req_n, 1'b1);
        gnt_n = 1'b1;
        step(2);
    endtask

    task automatic t_empty_session();
        eng_req = 1'b1;
        step(1);
        eng_req = 1'b0;
        step(2);
        chk("R4 held after engine drop", req_n, 1'b0);
        gnt_n = 1'b0;
        step(1);
        chk("R6 no force on grant edge", force_as_n, 1'b1);
        step(1);
        chk("R6 forced strobe low", force_as_n, 1'b0);
        chk("R6 req_n still low during force", req_n, 1'b0);
        step(1);
        chk("R6 force ends", force_as_n, 1'b1);
        chk("R6 release after force", req_n, 1'b1);
        gnt_n = 1'b1;
        step(2);
    endtask

    task automatic t_early_strobe();
        eng_req = 1'b1;
        step(1);
        eng_as_n = 1'b0;
        step(1);
        eng_as_n = 1'b1; gnt_n = 1'b0;
        step(1);
        eng_req = 1'b0;
        step(1);
        chk("R7 pre-grant strobe ignored", force_as_n, 1'b0);
        step(1);
        chk("R7 release after force", req_n, 1'b1);
        gnt_n = 1'b1;
        step(2);
    endtask

    task automatic t_grant_held();
        eng_req = 1'b1;
        step(1);
        gnt_n = 1'b0;
        step(1);
        eng_as_n = 1'b0; eng_req = 1'b0;
        step(1);
        eng_as_n = 1'b1;
        chk("R5 released", req_n, 1'b1);
        eng_req = 1'b1;
        step(3);
        chk("R8 no launch while grant low", req_n, 1'b1);
        gnt_n = 1'b1;
        step(1);
        chk("R8 launch once grant high", req_n, 1'b0);
        gnt_n = 1'b0;
        step(1);
        eng_as_n = 1'b0; eng_req = 1'b0;
        step(1);
        eng_as_n = 1'b1; gnt_n = 1'b1;
        step(2);
    endtask

    initial begin
        t_reset();
        t_plain_launch();
        t_lock_same_edge();
        t_lock_in_session();
        t_empty_session();
        t_early_strobe();
        t_grant_held();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule